// File: doc/BRIEF.md
# Variable-Length Instruction Aligner

This block sits between instruction fetch and decode. Fetched bytes arrive in little-endian order, a fixed number per beat, under a valid/ready handshake, and collect in a small byte window. Each cycle the block looks at the major opcode and emits at most one aligned instruction, along with a two-bit length code and a class tag. The major opcode is the top six bits of the halfword made of window bytes 2 and 3, so those bytes are examined before bytes 0 and 1.

When the extended-format input is high, the eight lowest opcodes select prefixed, compressed and vector-block forms of 16, 32, 48 or 64 bits. For those forms the block reorders halfwords and takes bytes out of sequence. A 16-bit instruction is lifted out of bytes 2 and 3 and leaves bytes 0 and 1 in place. A 48-bit instruction is assembled from byte pairs in the order (2,3), (0,1), (4,5). When the extended-format input is low, every instruction is a plain 32-bit word. A flush input empties the window for a redirect, and alignment restarts at the first byte that arrives after it.

Top module: `insn_aligner`

## Requirements
- R1: After reset `outValid` is low and `inReady` is high.
- R2: With `modeExt` low, every instruction is 4 bytes long, and `outLen`=1, `outClass`=0. `outInsn` is `{32'b0, b3, b2, b1, b0}`, where bN is window byte N and `inData[7:0]` is the earliest byte of a beat.
- R3: With `modeExt` high, the opcode is `b3[7:2]`. Opcodes 0 and 1 give class 1 with length code 3. Opcodes 2 and 3 give class 2 with length code 2. Opcodes 4 and 5 give class 3 with length code 1. Opcode 6 gives class 4 with length code 0. Opcode 7 gives class 5 with length code 1. Every other opcode gives class 0 with length code 1. Length codes 0 to 3 stand for 16, 32, 48 and 64 bits.
- R4: A 16-bit instruction is output as `{48'b0, b3, b2}`. Only bytes 2 and 3 are consumed, so the next window is b0, b1, b4, b5 and so on.
- R5: A 48-bit instruction is output as `{16'b0, b3, b2, b1, b0, b5, b4}` and consumes bytes 0 to 5.
- R6: A 64-bit instruction is output as `{b3, b2, b1, b0, b7, b6, b5, b4}` and consumes bytes 0 to 7.
- R7: `outValid` stays low until the window holds at least 4 bytes, or 6 bytes for the 48-bit form, or 8 bytes for the 64-bit form.
- R8: While `outValid` is high and `outReady` is low, `outInsn`, `outLen` and `outClass` hold their values, provided that neither flush nor the mode changes.
- R9: While `flush` is high, both `outValid` and `inReady` are low. The window is then empty, and the next instruction is built only from bytes supplied after the flush.
- R10: `inReady` is high exactly when the window has room for a full beat, that is, when its occupancy is at most WIN_BYTES − IN_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeExt | input | 1 | Enables the extended opcode interpretation |
| flush | input | 1 | Empties the window on a redirect |
| inValid | input | 1 | Input beat valid |
| inData | input | IN_BYTES*8 | Input beat, earliest byte in the low bits |
| inReady | output | 1 | Window can accept a beat |
| outValid | output | 1 | Aligned instruction available |
| outReady | input | 1 | Consumer takes the instruction |
| outInsn | output | 64 | Assembled instruction word |
| outLen | output | 2 | Length code: 0=16, 1=32, 2=48, 3=64 bits |
| outClass | output | 3 | Instruction class tag |

## Verification
The bench uses the default build, a 16-byte window filled 4 bytes per beat. This keeps occupancy small enough that every fill level, from empty to full, is reached many times. It sweeps all 64 opcode values in both modes, and the tail of each sweep stream checks the stall rule on a partial window. Long byte streams biased toward the low opcodes then mix all forms back to back, under random input gaps and output stalls. These runs exercise simultaneous push and out-of-order pop at every occupancy, a 16-bit pop followed by re-examination of the shifted window, and the full-window point at which ready must drop.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

  typedef enum logic [1:0] {
    LEN16 = 2'd0,
    LEN32 = 2'd1,
    LEN48 = 2'd2,
    LEN64 = 2'd3
  } lenCode_t;

  typedef enum logic [2:0] {
    CLS_PLAIN  = 3'd0,
    CLS_PFX64  = 3'd1,
    CLS_PFX48  = 3'd2,
    CLS_PFX32  = 3'd3,
    CLS_COMP16 = 3'd4,
    CLS_VBLOCK = 3'd5
  } insnClass_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     clear;
    logic     push;
    logic     pop;
    lenCode_t popLen;
  } dpCtrl_t;

  function automatic insnClass_t classify(input logic [5:0] major, input logic extOn);
    insnClass_t c;
    c = CLS_PLAIN;
    if (extOn) begin
      case (major)
        6'd0, 6'd1: c = CLS_PFX64;
        6'd2, 6'd3: c = CLS_PFX48;
        6'd4, 6'd5: c = CLS_PFX32;
        6'd6:       c = CLS_COMP16;
        6'd7:       c = CLS_VBLOCK;
        default:    c = CLS_PLAIN;
      endcase
    end
    return c;
  endfunction

  function automatic lenCode_t lengthOf(input insnClass_t c);
    lenCode_t l;
    case (c)
      CLS_PFX64:  l = LEN64;
      CLS_PFX48:  l = LEN48;
      CLS_COMP16: l = LEN16;
      default:    l = LEN32;
    endcase
    return l;
  endfunction

  // bytes that must be present before the form can be emitted
  function automatic int needOf(input lenCode_t l);
    int n;
    case (l)
      LEN64:   n = 8;
      LEN48:   n = 6;
      default: n = 4;
    endcase
    return n;
  endfunction

  // bytes removed from the window when the form is emitted
  function automatic int dropOf(input lenCode_t l);
    int n;
    case (l)
      LEN16:   n = 2;
      LEN32:   n = 4;
      LEN48:   n = 6;
      default: n = 8;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/aligner_ctrl.sv
module aligner_ctrl
  import aligner_pkg::*;
#(
  parameter int WIN_BYTES = 16,
  parameter int IN_BYTES  = 4,
  localparam int CNT_W    = $clog2(WIN_BYTES + 1)
) (
  input  logic [CNT_W-1:0] fill,
  input  logic [7:0]       opByte,
  input  logic             modeExt,
  input  logic             flush,
  input  logic             inValid,
  input  logic             outReady,
  output dpCtrl_t          ctl,
  output logic             outValid,
  output logic             inReady,
  output lenCode_t         insnLen,
  output insnClass_t       insnClass
);

  localparam int ROOM = WIN_BYTES - IN_BYTES;

  logic [5:0] major;
  int         needBytes;
  int         fillInt;

  always_comb begin
    major     = opByte[7:2];
    insnClass = classify(major, modeExt);
    insnLen   = lengthOf(insnClass);
    needBytes = needOf(insnLen);
    fillInt   = int'(fill);

    outValid = !flush && (fillInt >= needBytes);
    inReady  = !flush && (fillInt <= ROOM);

    ctl.clear  = flush;
    ctl.pop    = outValid && outReady;
    ctl.push   = inValid && inReady;
    ctl.popLen = insnLen;
  end

endmodule

// File: rtl/aligner_dp.sv
module aligner_dp
  import aligner_pkg::*;
#(
  parameter int WIN_BYTES = 16,
  parameter int IN_BYTES  = 4,
  localparam int CNT_W    = $clog2(WIN_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtrl_t               ctl,
  input  logic [IN_BYTES*8-1:0] inData,
  output logic [CNT_W-1:0]      fill,
  output logic [7:0]            opByte,
  output logic [63:0]           insnWord
);

  logic [7:0]       bufQ    [WIN_BYTES];
  logic [7:0]       bufD    [WIN_BYTES];
  logic [7:0]       shifted [WIN_BYTES];
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntD;

  int dropN;
  int skipLo;
  int baseIdx;

  // window update: out-of-order removal, then append of a new beat
  always_comb begin
    dropN  = dropOf(ctl.popLen);
    skipLo = (ctl.popLen == LEN16) ? 2 : 0;

    for (int i = 0; i < WIN_BYTES; i++) begin
      shifted[i] = bufQ[i];
    end
    if (ctl.pop) begin
      for (int i = 0; i < WIN_BYTES; i++) begin
        if (i >= skipLo) begin
          if (i + dropN < WIN_BYTES) begin
            shifted[i] = bufQ[i + dropN];
          end else begin
            shifted[i] = '0;
          end
        end
      end
    end

    baseIdx = ctl.pop ? (int'(cntQ) - dropN) : int'(cntQ);

    for (int i = 0; i < WIN_BYTES; i++) begin
      bufD[i] = shifted[i];
    end
    if (ctl.push) begin
      for (int i = 0; i < WIN_BYTES; i++) begin
        for (int k = 0; k < IN_BYTES; k++) begin
          if (i == baseIdx + k) begin
            bufD[i] = inData[k*8 +: 8];
          end
        end
      end
    end
    cntD = CNT_W'(baseIdx + (ctl.push ? IN_BYTES : 0));

    if (ctl.clear) begin
      cntD = '0;
      for (int i = 0; i < WIN_BYTES; i++) begin
        bufD[i] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      for (int i = 0; i < WIN_BYTES; i++) begin
        bufQ[i] <= '0;
      end
    end else begin
      cntQ <= cntD;
      for (int i = 0; i < WIN_BYTES; i++) begin
        bufQ[i] <= bufD[i];
      end
    end
  end

  // halfword reordering for the emitted form
  always_comb begin
    case (ctl.popLen)
      LEN16:   insnWord = {48'b0, bufQ[3], bufQ[2]};
      LEN32:   insnWord = {32'b0, bufQ[3], bufQ[2], bufQ[1], bufQ[0]};
      LEN48:   insnWord = {16'b0, bufQ[3], bufQ[2], bufQ[1], bufQ[0], bufQ[5], bufQ[4]};
      default: insnWord = {bufQ[3], bufQ[2], bufQ[1], bufQ[0], bufQ[7], bufQ[6], bufQ[5], bufQ[4]};
    endcase
  end

  assign fill   = cntQ;
  assign opByte = bufQ[3];

endmodule

// File: rtl/insn_aligner.sv
module insn_aligner
  import aligner_pkg::*;
#(
  parameter int WIN_BYTES = 16,
  parameter int IN_BYTES  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  modeExt,
  input  logic                  flush,
  input  logic                  inValid,
  input  logic [IN_BYTES*8-1:0] inData,
  output logic                  inReady,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [63:0]           outInsn,
  output logic [1:0]            outLen,
  output logic [2:0]            outClass
);

  localparam int CNT_W = $clog2(WIN_BYTES + 1);

  dpCtrl_t          ctl;
  logic [CNT_W-1:0] fill;
  logic [7:0]       opByte;
  lenCode_t         insnLen;
  insnClass_t       insnClass;

  aligner_ctrl #(.WIN_BYTES(WIN_BYTES), .IN_BYTES(IN_BYTES)) ctrlInst (
    .fill(fill),
    .opByte(opByte),
    .modeExt(modeExt),
    .flush(flush),
    .inValid(inValid),
    .outReady(outReady),
    .ctl(ctl),
    .outValid(outValid),
    .inReady(inReady),
    .insnLen(insnLen),
    .insnClass(insnClass)
  );

  aligner_dp #(.WIN_BYTES(WIN_BYTES), .IN_BYTES(IN_BYTES)) dpInst (
    .clk(clk),
    .rstN(rstN),
    .ctl(ctl),
    .inData(inData),
    .fill(fill),
    .opByte(opByte),
    .insnWord(outInsn)
  );

  assign outLen   = insnLen;
  assign outClass = insnClass;

endmodule

// File: rtl/insn_aligner_chk.sv
module insn_aligner_chk (
  input logic        clk,
  input logic        rstN,
  input logic        modeExt,
  input logic        flush,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [63:0] outInsn,
  input logic [1:0]  outLen,
  input logic [2:0]  outClass
);

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (!outValid && !inReady)); // R9

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !flush) |=>
      (flush || !$stable(modeExt) ||
       (outValid && $stable(outInsn) && $stable(outLen) && $stable(outClass)))); // R8

  AST_PLAIN_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !modeExt) |-> (outLen == 2'd1 && outClass == 3'd0)); // R2

  AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLen == 2'd0) |-> (outInsn[63:16] == 48'b0)); // R4

  AST_WIDE48_ZEXT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLen == 2'd2) |-> (outInsn[63:48] == 16'b0)); // R5

  AST_PFX64_OPCODE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLen == 2'd3) |-> (outInsn[63:59] == 5'b0 && outClass == 3'd1)); // R6

  AST_COMP_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outClass == 3'd4) |-> (outLen == 2'd0 && outInsn[15:10] == 6'd6)); // R3

endmodule

bind insn_aligner insn_aligner_chk chkInst (
  .clk(clk),
  .rstN(rstN),
  .modeExt(modeExt),
  .flush(flush),
  .inReady(inReady),
  .outValid(outValid),
  .outReady(outReady),
  .outInsn(outInsn),
  .outLen(outLen),
  .outClass(outClass)
);

// File: tb/insn_aligner_test.sv
`timescale 1ns/1ps
module insn_aligner_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeExt = 1'b0;
  logic        flush = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        inReady;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [63:0] outInsn;
  logic [1:0]  outLen;
  logic [2:0]  outClass;

  int checkCnt = 0;
  int failCnt  = 0;
  logic finished = 1'b0;
  logic [31:0] rs = 32'h1234_5678;

  logic [7:0]  stream  [$];
  logic [63:0] expWord [$];
  logic [1:0]  expLen  [$];
  logic [2:0]  expCls  [$];

  always #2 clk = ~clk;

  insn_aligner uut (
    .clk(clk), .rstN(rstN), .modeExt(modeExt), .flush(flush),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outInsn(outInsn),
    .outLen(outLen), .outClass(outClass)
  );

  task automatic chk(input string req, input string what, input logic ok,
                     input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic nextRand(output logic [31:0] r);
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    r  = rs;
  endtask

  // arithmetic model of the alignment rules
  task automatic buildExpected(input logic m);
    logic [7:0]  q [$];
    logic [5:0]  op;
    logic [1:0]  len;
    logic [2:0]  cls;
    logic [63:0] w;
    int          need;
    q = stream;
    expWord.delete(); expLen.delete(); expCls.delete();
    while (q.size() >= 4) begin
      op = q[3][7:2];
      cls = 3'd0; len = 2'd1;
      if (m && op < 6'd8) begin
        case (op)
          6'd0, 6'd1: begin cls = 3'd1; len = 2'd3; end
          6'd2, 6'd3: begin cls = 3'd2; len = 2'd2; end
          6'd4, 6'd5: begin cls = 3'd3; len = 2'd1; end
          6'd6:       begin cls = 3'd4; len = 2'd0; end
          default:    begin cls = 3'd5; len = 2'd1; end
        endcase
      end
      need = (len == 2'd3) ? 8 : (len == 2'd2) ? 6 : 4;
      if (q.size() < need) break;
      case (len)
        2'd0: begin
          w = {48'b0, q[3], q[2]};
          q.delete(3); q.delete(2);
        end
        2'd1: begin
          w = {32'b0, q[3], q[2], q[1], q[0]};
          repeat (4) void'(q.pop_front());
        end
        2'd2: begin
          w = {16'b0, q[3], q[2], q[1], q[0], q[5], q[4]};
          repeat (6) void'(q.pop_front());
        end
        default: begin
          w = {q[3], q[2], q[1], q[0], q[7], q[6], q[5], q[4]};
          repeat (8) void'(q.pop_front());
        end
      endcase
      expWord.push_back(w); expLen.push_back(len); expCls.push_back(cls);
    end
  endtask

  function automatic string reqOf(input logic m, input logic [1:0] len);
    if (!m) return "R2";
    case (len)
      2'd0:    return "R4";
      2'd2:    return "R5";
      2'd3:    return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1; inValid = 1'b0; outReady = 1'b0;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic pushBeat(input logic [31:0] d);
    @(negedge clk);
    inValid = 1'b1; inData = d;
    @(negedge clk);
    inValid = 1'b0;
    #1;
  endtask

  // drive the current stream and compare every emitted instruction
  task automatic runStream(input logic m, input int gapMod, input int stallMod);
    int ptr = 0;
    int idx = 0;
    int t = 0;
    logic held = 1'b0;
    logic [63:0] hW;
    logic [1:0] hL;
    logic [2:0] hC;
    logic [31:0] r;
    buildExpected(m);
    modeExt = m;
    doFlush();
    while ((idx < expWord.size() || ptr < stream.size()) && t < 4000) begin
      nextRand(r);
      inValid = (ptr < stream.size()) && (gapMod == 0 || (r[7:0] % gapMod) != 0);
      if (ptr < stream.size())
        inData = {stream[ptr+3], stream[ptr+2], stream[ptr+1], stream[ptr]};
      outReady = (stallMod == 0) || ((r[15:8] % stallMod) != 0);
      #1;
      if (held) begin
        chk("R8", "held output", outValid && outInsn == hW && outLen == hL && outClass == hC,
            {outInsn}, hW);
      end
      held = outValid && !outReady;
      hW = outInsn; hL = outLen; hC = outClass;
      if (outValid && outReady) begin
        if (idx < expWord.size()) begin
          chk(reqOf(m, expLen[idx]), "word", outInsn == expWord[idx], outInsn, expWord[idx]);
          chk(m ? "R3" : "R2", "len/class", {outLen, outClass} == {expLen[idx], expCls[idx]},
              64'({outLen, outClass}), 64'({expLen[idx], expCls[idx]}));
          idx++;
        end else begin
          chk("R7", "unexpected output", 1'b0, outInsn, 64'b0);
        end
      end
      if (inValid && inReady) ptr += 4;
      @(negedge clk);
      t++;
    end
    if (t >= 4000) chk("R7", "stream timeout", 1'b0, 64'(idx), 64'(expWord.size()));
    inValid = 1'b0; outReady = 1'b1;
    #1;
    chk("R7", "partial window stalls", !outValid, 64'(outValid), 64'b0);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] r;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1", "reset outValid", !outValid, 64'(outValid), 64'b0);
    chk("R1", "reset inReady", inReady, 64'(inReady), 64'b1);

    // opcode sweep in both modes
    for (int m = 0; m < 2; m++) begin
      for (int op = 0; op < 64; op++) begin
        stream.delete();
        for (int i = 0; i < 12; i++) stream.push_back(8'((op * 7 + i * 29) & 8'hff));
        stream[3]  = {6'(op), 2'b01};
        stream[5]  = 8'hA1;
        stream[9]  = 8'hE5;
        stream[11] = 8'hF3;
        runStream(m[0], 0, 0);
      end
    end

    // long mixed streams biased toward the low opcodes
    for (int pass = 0; pass < 3; pass++) begin
      stream.delete();
      for (int i = 0; i < 320; i++) begin
        nextRand(r);
        b = r[7:0];
        if (r[9:8] != 2'b00) b = b & 8'h1F;
        stream.push_back(b);
      end
      runStream(pass != 2, (pass == 0) ? 3 : 0, (pass == 1) ? 0 : 3);
    end

    // R7 and R6: 64-bit form waits for its second word
    modeExt = 1'b1;
    doFlush();
    pushBeat(32'h0011_2233);
    chk("R7", "64-bit needs 8 bytes", !outValid, 64'(outValid), 64'b0);
    pushBeat(32'h7766_5544);
    chk("R7", "64-bit ready at 8 bytes", outValid, 64'(outValid), 64'b1);
    chk("R6", "64-bit word", outInsn == 64'h0011_2233_7766_5544, outInsn, 64'h0011_2233_7766_5544);

    // R10: ready while a beat fits, low when full
    pushBeat(32'hFC00_0000);
    chk("R10", "ready at 12 bytes", inReady, 64'(inReady), 64'b1);
    pushBeat(32'hFC00_0000);
    chk("R10", "not ready at 16 bytes", !inReady, 64'(inReady), 64'b0);

    // R9: flush clears and restarts at new data
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk("R9", "quiet during flush", !outValid && !inReady, {62'b0, outValid, inReady}, 64'b0);
    @(negedge clk);
    flush = 1'b0;
    #1;
    chk("R9", "empty after flush", !outValid && inReady, {62'b0, outValid, inReady}, 64'b1);
    pushBeat(32'hFC01_0203);
    chk("R9", "restart word", outValid && outInsn == 64'h0000_0000_FC01_0203, outInsn,
        64'h0000_0000_FC01_0203);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule